// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal and vertical timing of an RGB video output from a pixel-rate clock enable and eight programmable segment lengths. Each line and each frame run through the same four segments: sync pulse, back porch, active region and front porch. Horizontal segments are counted in pixel-enable cycles and vertical segments in whole lines. Every length is programmed as its count minus one. In interlaced use, software programs the already-halved field values.

The generator sets data-enable and the position inside the active area, and it reports which vertical segment is running. It keeps a wrapping frame identifier that steps when each vertical sync begins, so software can tell frames apart by signed difference. It also raises a frame interrupt when the vertical front porch begins. Timing values are captured once per frame. When output is switched off, the current frame still runs to its end.

Top module: `vtg_top`

## Requirements
- R1: After reset hsync, vsync, de, irq_pend and irq_pulse are 0, stopped is 1, frame_id is 0 and vstatus is 0.
- R2: Each line is (h_sync_m1+1) cycles with pix_ce high and hsync high, then h_back_m1+1, h_act_m1+1 and h_front_m1+1 cycles in that order, with hsync low outside the first segment.
- R3: Each frame is v_sync_m1+1 lines with vsync high, then v_back_m1+1, v_act_m1+1 and v_front_m1+1 lines. vstatus codes the vertical segment: 0 sync, 1 back porch, 2 active, 3 front porch.
- R4: de is high exactly when both the horizontal and the vertical segment are active. pix_x and line_y then give the 0-based column and row inside the active area, and both are 0 while de is low.
- R5: While pix_ce is low, no output changes.
- R6: frame_id increases by one on the clock edge that starts vertical sync, including the first frame after output is enabled. It wraps from 2^FID_W-1 to 0.
- R7: soft_rst sets frame_id to 0. If it coincides with a frame start, frame_id becomes 0 and does not increment.
- R8: On the edge that enters the vertical front porch, irq_pulse is high for one cycle and irq_pend becomes 1. irq_pend stays set until irq_clr is high at an edge. A clear that coincides with a new front-porch start leaves irq_pend at 1.
- R9: Timing inputs are captured only when a frame starts. A change during a frame leaves that frame's timing unchanged and applies from the next frame.
- R10: When out_en is low at the end of a frame, the frame completes normally. The generator then idles with stopped high, hsync, vsync and de low, and frame_id unchanged. A later out_en high starts a new frame at the next pix_ce.
- R11: field is 0 for the first frame after enable and whenever interlace is low at a frame start. With interlace high, field inverts at every frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| pix_ce | input | 1 | Pixel enable; one pixel per high cycle |
| out_en | input | 1 | Output enable, acted on at frame boundaries |
| interlace | input | 1 | Field alternation enable |
| soft_rst | input | 1 | Clears the frame identifier |
| irq_clr | input | 1 | Clears irq_pend (write-one style) |
| h_sync_m1 | input | TW | Horizontal sync width minus one |
| h_back_m1 | input | TW | Horizontal back porch minus one |
| h_act_m1 | input | TW | Active pixels minus one |
| h_front_m1 | input | TW | Horizontal front porch minus one |
| v_sync_m1 | input | TW | Vertical sync lines minus one |
| v_back_m1 | input | TW | Vertical back porch lines minus one |
| v_act_m1 | input | TW | Active lines minus one |
| v_front_m1 | input | TW | Vertical front porch lines minus one |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_x | output | TW | Column within active area |
| line_y | output | TW | Row within active area |
| vstatus | output | 2 | Vertical segment code |
| field | output | 1 | Current field parity |
| frame_id | output | FID_W | Wrapping frame identifier |
| irq_pulse | output | 1 | One-cycle front-porch-start strobe |
| irq_pend | output | 1 | Sticky frame interrupt |
| stopped | output | 1 | Generator idle |

## Verification
Two pairs of events can land on the same edge. The first is a software clear of the pending interrupt and the edge that enters the vertical front porch. The second is a frame-identifier reset and the edge that starts vertical sync. The bench counts pixels from a known frame start and raises irq_clr, or soft_rst, in the cycle just before the colliding edge. It then expects irq_pend still set, or frame_id equal to zero rather than one. Other cases check that a clear away from the front porch does drop the flag, and that an identifier reset in mid-frame is followed by a normal increment at the next frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int SEG_N = 4;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } phase_e;
endpackage

// File: rtl/vtg_phase_ctr.sv
// Walks one axis through sync, back porch, active and front porch.
module vtg_phase_ctr
   import vtg_pkg::*;
#(
   parameter int W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    restart,
   input  logic                    adv,
   input  logic [SEG_N-1:0][W-1:0] len_m1,
   output phase_e                  phase,
   output logic [W-1:0]            cnt,
   output logic                    span_end
);
   logic [1:0] idx;
   logic       seg_done;

   assign idx      = phase;
   assign seg_done = (cnt == len_m1[idx]);
   assign span_end = seg_done && (phase == PH_FRONT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (restart) begin
         phase <= PH_SYNC;
         cnt   <= '0;
      end else if (adv) begin
         if (seg_done) begin
            cnt   <= '0;
            phase <= phase_e'(idx + 2'd1);
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R2/R3: the position never runs past the current segment length
   assert_cnt_in_seg_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= len_m1[idx]);
endmodule

// File: rtl/vtg_frame_id.sv
// Wrapping frame identifier; clear has priority over increment.
module vtg_frame_id #(
   parameter int FID_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [FID_W-1:0] id
);
   always_ff @(posedge clk) begin
      if (!rst_n)   id <= '0;
      else if (clr) id <= '0;
      else if (inc) id <= id + 1'b1;
   end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
   import vtg_pkg::*;
#(
   parameter int TW    = 12,
   parameter int FID_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_ce,
   input  logic             out_en,
   input  logic             interlace,
   input  logic             soft_rst,
   input  logic             irq_clr,
   input  logic [TW-1:0]    h_sync_m1,
   input  logic [TW-1:0]    h_back_m1,
   input  logic [TW-1:0]    h_act_m1,
   input  logic [TW-1:0]    h_front_m1,
   input  logic [TW-1:0]    v_sync_m1,
   input  logic [TW-1:0]    v_back_m1,
   input  logic [TW-1:0]    v_act_m1,
   input  logic [TW-1:0]    v_front_m1,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [TW-1:0]    pix_x,
   output logic [TW-1:0]    line_y,
   output logic [1:0]       vstatus,
   output logic             field,
   output logic [FID_W-1:0] frame_id,
   output logic             irq_pulse,
   output logic             irq_pend,
   output logic             stopped
);
   localparam int AXES = 2;
   localparam int AX_H = 0;
   localparam int AX_V = 1;

   if (TW < 2) begin : g_bad_tw
      $error("vtg_top: TW must be at least 2");
   end
   if (FID_W < 2) begin : g_bad_fid
      $error("vtg_top: FID_W must be at least 2");
   end

   logic                    running;
   logic [SEG_N-1:0][TW-1:0] shd [AXES];
   phase_e                  ph      [AXES];
   logic [TW-1:0]           cnt     [AXES];
   logic                    span_end[AXES];
   logic                    adv     [AXES];

   logic start_idle, frame_wrap, start_frame, fp_start, v_act_end;

   assign start_idle  = !running && out_en && pix_ce;
   assign frame_wrap  = running && pix_ce && span_end[AX_H] && span_end[AX_V];
   assign start_frame = start_idle || (frame_wrap && out_en);
   assign adv[AX_H]   = running && pix_ce;
   assign adv[AX_V]   = running && pix_ce && span_end[AX_H];
   assign v_act_end   = (ph[AX_V] == PH_ACT) && (cnt[AX_V] == shd[AX_V][2]);
   assign fp_start    = running && pix_ce && span_end[AX_H] && v_act_end;

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      vtg_phase_ctr #(.W(TW)) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .restart  (start_frame),
         .adv      (adv[a]),
         .len_m1   (shd[a]),
         .phase    (ph[a]),
         .cnt      (cnt[a]),
         .span_end (span_end[a])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         shd[AX_H] <= '0;
         shd[AX_V] <= '0;
         field   <= 1'b0;
      end else if (start_frame) begin
         running   <= 1'b1;
         shd[AX_H] <= {h_front_m1, h_act_m1, h_back_m1, h_sync_m1};
         shd[AX_V] <= {v_front_m1, v_act_m1, v_back_m1, v_sync_m1};
         field     <= (start_idle || !interlace) ? 1'b0 : !field;
      end else if (frame_wrap) begin
         running <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_pulse <= 1'b0;
         irq_pend  <= 1'b0;
      end else begin
         irq_pulse <= fp_start;
         if (fp_start)     irq_pend <= 1'b1;
         else if (irq_clr) irq_pend <= 1'b0;
      end
   end

   vtg_frame_id #(.FID_W(FID_W)) u_fid (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .inc   (start_frame),
      .id    (frame_id)
   );

   assign hsync   = running && (ph[AX_H] == PH_SYNC);
   assign vsync   = running && (ph[AX_V] == PH_SYNC);
   assign de      = running && (ph[AX_H] == PH_ACT) && (ph[AX_V] == PH_ACT);
   assign pix_x   = de ? cnt[AX_H] : '0;
   assign line_y  = de ? cnt[AX_V] : '0;
   assign vstatus = ph[AX_V];
   assign stopped = !running;

   assert_de_no_sync_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!hsync && !vsync));

   assert_fid_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(vsync) && !$past(soft_rst)) |-> (frame_id == $past(frame_id) + 1'b1));

   assert_fid_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_rst) |-> (frame_id == '0));

   assert_irq_in_front_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> (vstatus == 2'd3));

   assert_shadow_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start_frame) |-> ($stable(shd[AX_H]) && $stable(shd[AX_V])));

   assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> (!hsync && !vsync && !de));
endmodule

// File: tb/tb_vtg_top.sv
module tb_vtg_top;
   localparam int TW = 12;
   localparam int FW = 4;
   localparam int IDM = 1 << FW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, pix_ce, out_en, interlace, soft_rst, irq_clr;
   logic [TW-1:0] h_sync_m1, h_back_m1, h_act_m1, h_front_m1;
   logic [TW-1:0] v_sync_m1, v_back_m1, v_act_m1, v_front_m1;
   logic hsync, vsync, de, field, irq_pulse, irq_pend, stopped;
   logic [TW-1:0] pix_x, line_y;
   logic [1:0] vstatus;
   logic [FW-1:0] frame_id;

   vtg_top #(.TW(TW), .FID_W(FW)) dut (
      .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .out_en(out_en),
      .interlace(interlace), .soft_rst(soft_rst), .irq_clr(irq_clr),
      .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1),
      .h_front_m1(h_front_m1), .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1),
      .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .line_y(line_y),
      .vstatus(vstatus), .field(field), .frame_id(frame_id),
      .irq_pulse(irq_pulse), .irq_pend(irq_pend), .stopped(stopped)
   );

   int n_chk = 0, n_fail = 0;
   int mh[4], mv[4];
   int e_h, e_v, e_a, e_i;

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic advn(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic set_live(int a, int b, int c, int d, int e, int f, int g, int h);
      h_sync_m1 = TW'(a - 1); h_back_m1 = TW'(b - 1);
      h_act_m1  = TW'(c - 1); h_front_m1 = TW'(d - 1);
      v_sync_m1 = TW'(e - 1); v_back_m1 = TW'(f - 1);
      v_act_m1  = TW'(g - 1); v_front_m1 = TW'(h - 1);
   endtask

   task automatic load_model();
      mh[0] = int'(h_sync_m1) + 1; mh[1] = int'(h_back_m1) + 1;
      mh[2] = int'(h_act_m1) + 1;  mh[3] = int'(h_front_m1) + 1;
      mv[0] = int'(v_sync_m1) + 1; mv[1] = int'(v_back_m1) + 1;
      mv[2] = int'(v_act_m1) + 1;  mv[3] = int'(v_front_m1) + 1;
   endtask

   function automatic int llen();
      return mh[0] + mh[1] + mh[2] + mh[3];
   endfunction

   function automatic int flen();
      return llen() * (mv[0] + mv[1] + mv[2] + mv[3]);
   endfunction

   function automatic int seg_of(int pos, int a, int b, int c);
      if (pos < a) return 0;
      if (pos < a + b) return 1;
      if (pos < a + b + c) return 2;
      return 3;
   endfunction

   task automatic clear_errs();
      e_h = 0; e_v = 0; e_a = 0; e_i = 0;
   endtask

   // Compare all timing outputs against the arithmetic model at frame position p
   task automatic cmp_point(int p);
      int ln, hp, hph, vph, ex, ey;
      bit ede, eirq;
      ln  = p / llen();
      hp  = p % llen();
      hph = seg_of(hp, mh[0], mh[1], mh[2]);
      vph = seg_of(ln, mv[0], mv[1], mv[2]);
      ede = (hph == 2) && (vph == 2);
      ex  = ede ? hp - mh[0] - mh[1] : 0;
      ey  = ede ? ln - mv[0] - mv[1] : 0;
      eirq = (ln == mv[0] + mv[1] + mv[2]) && (hp == 0);
      if (hsync !== (hph == 0)) e_h++;
      if (vsync !== (vph == 0) || int'(vstatus) != vph) e_v++;
      if (de !== ede || int'(pix_x) != ex || int'(line_y) != ey) e_a++;
      if (irq_pulse !== eirq) e_i++;
   endtask

   task automatic walk(int from, int to);
      for (int p = from; p <= to; p++) begin
         cmp_point(p);
         if (p < to) tick();
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pix_ce = 1'b0; out_en = 1'b0; interlace = 1'b0;
      soft_rst = 1'b0; irq_clr = 1'b0;
      set_live(2, 2, 4, 2, 1, 1, 2, 1);
      advn(4);
      rst_n = 1'b1;
      tick();
      chk("R1 hsync", hsync, 0);
      chk("R1 vsync", vsync, 0);
      chk("R1 de", de, 0);
      chk("R1 stopped", stopped, 1);
      chk("R1 frame_id", frame_id, 0);
      chk("R1 vstatus", vstatus, 0);
      chk("R1 irq_pend", irq_pend, 0);
      chk("R1 irq_pulse", irq_pulse, 0);
   endtask

   task automatic t_first_frame();
      load_model();
      out_en = 1'b1; pix_ce = 1'b1;
      tick();
      chk("R6 first frame id", frame_id, 1);
      chk("R10 running after enable", stopped, 0);
      clear_errs();
      walk(0, flen() - 1);
      chk("R2 hsync pattern A", e_h, 0);
      chk("R3 vsync/vstatus pattern A", e_v, 0);
      chk("R4 de/position pattern A", e_a, 0);
      chk("R8 irq pulse pattern A", e_i, 0);
      chk("R8 pend after front porch", irq_pend, 1);
      tick();
      chk("R6 second frame id", frame_id, 2);
   endtask

   task automatic t_shadow();
      set_live(1, 3, 5, 1, 2, 2, 3, 2);
      clear_errs();
      walk(0, flen() - 1);
      chk("R9 old timing kept for current frame", e_h + e_v + e_a + e_i, 0);
      tick();
      load_model();
      clear_errs();
      walk(0, flen() - 1);
      chk("R2 hsync pattern B", e_h, 0);
      chk("R3 vsync/vstatus pattern B", e_v, 0);
      chk("R4 de/position pattern B", e_a, 0);
      chk("R9 new timing at next frame", e_i, 0);
      tick();
   endtask

   task automatic t_stall();
      logic [FW-1:0] id0;
      clear_errs();
      walk(0, 20);
      id0 = frame_id;
      pix_ce = 1'b0;
      for (int i = 0; i < 5; i++) begin
         tick();
         cmp_point(20);
      end
      chk("R5 frame_id frozen", frame_id, id0);
      pix_ce = 1'b1;
      tick();
      walk(21, flen() - 1);
      chk("R5 outputs frozen while pix_ce low", e_h + e_v + e_a + e_i, 0);
      tick();
   endtask

   task automatic t_irq();
      int pfp;
      pfp = (mv[0] + mv[1] + mv[2]) * llen();
      chk("R8 pend held", irq_pend, 1);
      irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R8 clear", irq_pend, 0);
      advn(pfp - 2);
      chk("R8 still clear before front porch", irq_pend, 0);
      irq_clr = 1'b1;
      tick();
      irq_clr = 1'b0;
      chk("R8 set wins over clear", irq_pend, 1);
      chk("R8 pulse at front porch", irq_pulse, 1);
      tick();
      chk("R8 pulse one cycle", irq_pulse, 0);
      advn(flen() - 1 - (pfp + 1));
      tick();
   endtask

   task automatic t_softrst();
      soft_rst = 1'b1;
      tick();
      soft_rst = 1'b0;
      chk("R7 mid-frame clear", frame_id, 0);
      advn(flen() - 2);
      soft_rst = 1'b1;
      tick();
      soft_rst = 1'b0;
      chk("R7 clear wins over increment", frame_id, 0);
      chk("R7 frame still started", vsync, 1);
      advn(flen());
      chk("R7 counting resumes", frame_id, 1);
   endtask

   task automatic t_interlace();
      chk("R11 progressive field", field, 0);
      interlace = 1'b1;
      advn(flen());
      chk("R11 first toggle", field, 1);
      advn(flen());
      chk("R11 second toggle", field, 0);
      advn(flen());
      chk("R11 third toggle", field, 1);
      interlace = 1'b0;
      advn(flen());
      chk("R11 back to progressive", field, 0);
   endtask

   task automatic t_stop();
      logic [FW-1:0] id0;
      id0 = frame_id;
      advn(7);
      out_en = 1'b0;
      clear_errs();
      walk(7, flen() - 1);
      chk("R10 frame completes after disable", e_h + e_v + e_a + e_i, 0);
      chk("R10 not stopped before frame end", stopped, 0);
      tick();
      chk("R10 stopped", stopped, 1);
      chk("R10 idle hsync", hsync, 0);
      chk("R10 idle vsync", vsync, 0);
      chk("R10 idle de", de, 0);
      chk("R10 id unchanged", frame_id, id0);
      advn(6);
      chk("R10 remains stopped", stopped, 1);
      chk("R10 id held while idle", frame_id, id0);
      out_en = 1'b1;
      tick();
      chk("R10 restart", stopped, 0);
      chk("R10 restart vsync", vsync, 1);
      chk("R6 id after restart", frame_id, (int'(id0) + 1) % IDM);
   endtask

   task automatic t_wrap();
      int n;
      n = (IDM - int'(frame_id)) % IDM;
      if (n == 0) n = IDM;
      advn(flen() * (n - 1));
      chk("R6 top value", frame_id, IDM - 1);
      advn(flen());
      chk("R6 wrap to zero", frame_id, 0);
   endtask

   initial begin
      t_reset();
      t_first_frame();
      t_shadow();
      t_stall();
      t_irq();
      t_softrst();
      t_interlace();
      t_stop();
      t_wrap();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule